// File: doc/BRIEF.md
# Matrix Keypad Scanner with Press Lock

This block reads a 4x4 matrix keypad. It drives the four row lines and reads the four column lines. When the keypad is idle, one row at a time is driven high, and the driven row advances every clock cycle. A column line is held low by a pull-down unless a closed key joins it to the driven row. The column lines enter through a two-stage synchronizer. The scanner tracks which row was driven when each synchronized sample was taken, so that it can attribute a closure to the correct row even though the synchronizer adds latency.

When a closure is seen, scanning stops and the scanner captures the row and the column pattern. It then drives only that row until the same pattern has been seen for a programmable number of cycles. Once that count is reached, it raises a one-cycle valid pulse and presents the hexadecimal code of the key.

After the pulse, all rows are driven high. The scanner waits there until the columns have read all-low for the same programmable count, and only then does scanning start again. While a key is held, every other key is locked out, and each press is reported exactly once.

Top module: `kp_scanner`

## Requirements
- R1: Reset is synchronous and active low on `rst_n`. While it is asserted, `row_o` is 4'b0001 and `key_valid_o` is 0.
- R2: While no column reads high, `row_o` is one-hot (bit n drives row n) and rotates toward the higher bit once per clock, wrapping from row 3 to row 0.
- R3: A closure that lasts fewer cycles than the qualification count `DEB_CYCLES` (default 4) produces no valid pulse.
- R4: During the cycle of the valid pulse, `row_o` drives only the row of the pressed key.
- R5: Each qualified press produces exactly one `key_valid_o` pulse, one cycle wide.
- R6: With column bit 0 as the leftmost column, the key codes are: row 0 gives 1,2,3,A; row 1 gives 4,5,6,B; row 2 gives 7,8,9,C; row 3 gives E,0,F,D. `key_code_o` shows the code of the last captured key.
- R7: If more than one column bit was captured for a press, the reported code is 4'hF.
- R8: From the cycle after the valid pulse until release is qualified, `row_o` is 4'b1111.
- R9: A key pressed while another key is held produces no pulse and leaves `key_code_o` unchanged. This holds even if it stays pressed after the first key is released.
- R10: A release gap shorter than `DEB_CYCLES` cycles does not end the hold. After all columns have read low for `DEB_CYCLES` cycles, scanning resumes and no second pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| col_i | input | 4 | Column sense lines, pulled low, asynchronous |
| row_o | output | 4 | Row drive lines, active high |
| key_valid_o | output | 1 | One-cycle pulse for each qualified press |
| key_code_o | output | 4 | Hexadecimal code of the captured key |

## Verification
Two actions can meet in the same interval: a new closure arriving, and the hold-and-release tracking of a key that is already held. The bench provokes this by pressing a second key while the first is held, then releasing the first key while the second stays down. The result is judged at the ports: no further pulse, an unchanged code, and all rows still driven. A release gap shorter than the qualification count is also applied during a hold, to check that release tracking does not hand control back to press detection early.

// File: rtl/kp_pkg.sv
package kp_pkg;

    localparam int NUM_ROWS = 4;
    localparam int NUM_COLS = 4;
    localparam int ROW_W    = $clog2(NUM_ROWS);

    typedef logic [ROW_W-1:0]    row_idx_t;
    typedef logic [NUM_COLS-1:0] col_vec_t;
    typedef logic [NUM_ROWS-1:0] row_vec_t;
    typedef logic [3:0]          key_code_t;

    typedef enum logic [1:0] {
        ST_SCAN,
        ST_PRESS,
        ST_FIRE,
        ST_HOLD
    } scan_state_t;

    typedef struct packed {
        row_idx_t row;
        col_vec_t col;
    } key_cap_t;

    // Maps captured row and column pattern to a hex code; anything other
    // than exactly one column bit yields 4'hF.
    function automatic key_code_t key_lookup(key_cap_t cap);
        int        hits;
        logic [1:0] cidx;
        hits = 0;
        cidx = '0;
        for (int j = 0; j < NUM_COLS; j++) begin
            if (cap.col[j]) begin
                hits++;
                cidx = 2'(j);
            end
        end
        if (hits != 1) return 4'hF;
        case ({cap.row, cidx})
            4'd0:  return 4'h1;
            4'd1:  return 4'h2;
            4'd2:  return 4'h3;
            4'd3:  return 4'hA;
            4'd4:  return 4'h4;
            4'd5:  return 4'h5;
            4'd6:  return 4'h6;
            4'd7:  return 4'hB;
            4'd8:  return 4'h7;
            4'd9:  return 4'h8;
            4'd10: return 4'h9;
            4'd11: return 4'hC;
            4'd12: return 4'hE;
            4'd13: return 4'h0;
            4'd14: return 4'hF;
            default: return 4'hD;
        endcase
    endfunction

endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)        stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d_i;
                else            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/kp_row_hist.sv
module kp_row_hist
    import kp_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  row_idx_t row_i,
    output row_idx_t row_old_o
);
    // Row index delayed to line up with the synchronized column sample.
    row_idx_t pipe [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_hist
            always_ff @(posedge clk) begin
                if (rst)         pipe[s] <= '0;
                else if (s == 0) pipe[s] <= row_i;
                else             pipe[s] <= pipe[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign row_old_o = pipe[DEPTH-1];
endmodule

// File: rtl/kp_scan_fsm.sv
module kp_scan_fsm
    import kp_pkg::*;
#(
    parameter int SETTLE     = 2,
    parameter int DEB_CYCLES = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  col_vec_t col_s_i,
    input  row_idx_t row_seen_i,
    output row_idx_t row_idx_o,
    output row_vec_t row_o,
    output logic     fire_o,
    output key_cap_t cap_o
);
    localparam int CNT_W     = $clog2(SETTLE + DEB_CYCLES + 1);
    localparam int PRESS_END = SETTLE + DEB_CYCLES - 1;
    localparam int REL_END   = DEB_CYCLES - 1;

    scan_state_t      state_q;
    row_idx_t         row_q;
    logic [CNT_W-1:0] cnt_q;
    key_cap_t         cap_q;

    function automatic row_idx_t next_row(row_idx_t r);
        return (r == row_idx_t'(NUM_ROWS-1)) ? '0 : row_idx_t'(r + 1'b1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SCAN;
            row_q   <= '0;
            cnt_q   <= '0;
            cap_q   <= '0;
        end else begin
            case (state_q)
                ST_SCAN: begin
                    if (cnt_q < CNT_W'(SETTLE)) begin
                        cnt_q <= cnt_q + 1'b1;
                        row_q <= next_row(row_q);
                    end else if (col_s_i != '0) begin
                        cap_q.row <= row_seen_i;
                        cap_q.col <= col_s_i;
                        cnt_q     <= '0;
                        state_q   <= ST_PRESS;
                    end else begin
                        row_q <= next_row(row_q);
                    end
                end
                ST_PRESS: begin
                    if (cnt_q < CNT_W'(SETTLE)) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else if (col_s_i == cap_q.col) begin
                        if (cnt_q == CNT_W'(PRESS_END)) begin
                            cnt_q   <= '0;
                            state_q <= ST_FIRE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end else begin
                        cnt_q   <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_FIRE: begin
                    cnt_q   <= '0;
                    state_q <= ST_HOLD;
                end
                default: begin
                    if (col_s_i != '0) begin
                        cnt_q <= '0;
                    end else if (cnt_q == CNT_W'(REL_END)) begin
                        cnt_q   <= '0;
                        row_q   <= '0;
                        state_q <= ST_SCAN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        case (state_q)
            ST_SCAN:          row_o = row_vec_t'(1) << row_q;
            ST_PRESS, ST_FIRE: row_o = row_vec_t'(1) << cap_q.row;
            default:          row_o = '1;
        endcase
    end

    assign fire_o    = (state_q == ST_FIRE);
    assign row_idx_o = row_q;
    assign cap_o     = cap_q;
endmodule

// File: rtl/kp_scanner.sv
module kp_scanner
    import kp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_CYCLES  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] col_i,
    output logic [3:0] row_o,
    output logic       key_valid_o,
    output logic [3:0] key_code_o
);
    logic     rst;
    col_vec_t col_s;
    row_idx_t row_idx;
    row_idx_t row_seen;
    key_cap_t cap;

    assign rst = ~rst_n;

    kp_sync #(.WIDTH(NUM_COLS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (col_i),
        .q_o (col_s)
    );

    kp_row_hist #(.DEPTH(SYNC_STAGES)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .row_i     (row_idx),
        .row_old_o (row_seen)
    );

    kp_scan_fsm #(.SETTLE(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .col_s_i    (col_s),
        .row_seen_i (row_seen),
        .row_idx_o  (row_idx),
        .row_o      (row_o),
        .fire_o     (key_valid_o),
        .cap_o      (cap)
    );

    assign key_code_o = key_lookup(cap);
endmodule

// File: rtl/kp_scanner_chk.sv
module kp_scanner_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] row_o,
    input logic       key_valid_o,
    input logic [3:0] key_code_o
);
    // R1: reset forces row 0 and no pulse
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (row_o == 4'b0001 && !key_valid_o));

    // R2 / R8: rows are either one-hot or all driven
    p_row_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(row_o) == 1 || row_o == 4'b1111));

    // R4: the pulse cycle drives a single row
    p_pulse_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |-> $countones(row_o) == 1);

    // R5: pulse lasts one cycle
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |=> !key_valid_o);

    // R8: hold drives every row after the pulse
    p_hold_after_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |=> row_o == 4'b1111);

    // R9: code is frozen while held
    p_code_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (row_o == 4'b1111) |=> $stable(key_code_o));
endmodule

bind kp_scanner kp_scanner_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_o       (row_o),
    .key_valid_o (key_valid_o),
    .key_code_o  (key_code_o)
);

// File: tb/tb_kp_scanner.sv
module tb_kp_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    // entry: {row[1:0], col[1:0], code[3:0]}
    localparam logic [7:0] VEC [NVEC] = '{
        8'b00_00_0001, 8'b00_01_0010, 8'b00_10_0011, 8'b00_11_1010,
        8'b01_00_0100, 8'b01_01_0101, 8'b01_10_0110, 8'b01_11_1011,
        8'b10_00_0111, 8'b10_01_1000, 8'b10_10_1001, 8'b10_11_1100,
        8'b11_00_1110, 8'b11_01_0000, 8'b11_10_1111, 8'b11_11_1101
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] col_i;
    logic [3:0] row_o;
    logic       key_valid_o;
    logic [3:0] key_code_o;
    logic [15:0] held = '0;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   pulses   = 0;
    logic [3:0] last_code = '0;
    logic [3:0] last_row  = '0;
    bit   done = 1'b0;

    kp_scanner dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .col_i       (col_i),
        .row_o       (row_o),
        .key_valid_o (key_valid_o),
        .key_code_o  (key_code_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Keypad model: a closed key connects its row drive to its column
    always_comb begin
        for (int c = 0; c < 4; c++) begin
            col_i[c] = 1'b0;
            for (int r = 0; r < 4; r++)
                if (held[r*4+c] && row_o[r] === 1'b1) col_i[c] = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && key_valid_o === 1'b1) begin
            pulses++;
            last_code = key_code_o;
            last_row  = row_o;
        end
    end

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_pulse(input int base);
        for (int k = 0; k < 60; k++) begin
            if (pulses != base) break;
            @(negedge clk);
        end
    endtask

    function automatic bit onehot(input logic [3:0] v);
        return $countones(v) == 1;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        logic [3:0] prev;
        cycles(3);
        // R1 reset state
        check(row_o == 4'b0001, "R1 row during reset", row_o, 4'b0001);
        check(key_valid_o == 1'b0, "R1 valid during reset", key_valid_o, 0);
        rst_n = 1'b1;
        #1;
        check(row_o == 4'b0001, "R1 row at reset release", row_o, 4'b0001);
        // R2 rotation with no key
        prev = row_o;
        for (int i = 0; i < 8; i++) begin
            cycles(1);
            check(row_o == {prev[2:0], prev[3]}, "R2 row rotation", row_o,
                  {prev[2:0], prev[3]});
            prev = row_o;
        end
        cycles(5);

        // R4 R5 R6 R8 R10: table walk over every key
        for (int i = 0; i < NVEC; i++) begin
            int r;
            int c;
            r = int'(VEC[i][7:6]);
            c = int'(VEC[i][5:4]);
            base = pulses;
            held[r*4+c] = 1'b1;
            wait_pulse(base);
            cycles(3);
            check(pulses == base + 1, "R5 one pulse per press", pulses, base + 1);
            check(last_code == VEC[i][3:0], "R6 key code", last_code, VEC[i][3:0]);
            check(last_row == (4'b0001 << r), "R4 row at pulse", last_row, 4'b0001 << r);
            check(row_o == 4'b1111, "R8 all rows while held", row_o, 4'b1111);
            held = '0;
            cycles(20);
            check(onehot(row_o), "R10 scan resumes", row_o, 4'b0001);
            check(pulses == base + 1, "R10 no pulse on release", pulses, base + 1);
        end

        // R3 short closure rejected
        base = pulses;
        held[0] = 1'b1;
        cycles(3);
        held = '0;
        cycles(30);
        check(pulses == base, "R3 short press ignored", pulses, base);

        // R7 two columns in one row
        base = pulses;
        held[8] = 1'b1;
        held[10] = 1'b1;
        wait_pulse(base);
        cycles(2);
        check(pulses == base + 1, "R7 pulse for multi-column", pulses, base + 1);
        check(last_code == 4'hF, "R7 multi-column code", last_code, 4'hF);
        held = '0;
        cycles(20);

        // R9 lockout of a second key
        base = pulses;
        held[3] = 1'b1;                   // row 0 col 3 -> A
        wait_pulse(base);
        cycles(2);
        held[5] = 1'b1;                   // row 1 col 1 -> 5
        cycles(8);
        held[3] = 1'b0;
        cycles(12);
        check(pulses == base + 1, "R9 no pulse for second key", pulses, base + 1);
        check(key_code_o == 4'hA, "R9 code unchanged", key_code_o, 4'hA);
        check(row_o == 4'b1111, "R9 hold kept by second key", row_o, 4'b1111);
        held = '0;
        cycles(20);
        check(pulses == base + 1, "R9 no pulse after release", pulses, base + 1);
        check(onehot(row_o), "R9 scan resumes", row_o, 4'b0001);

        // R10 short release gap does not end the hold
        base = pulses;
        held[10] = 1'b1;                  // row 2 col 2 -> 9
        wait_pulse(base);
        cycles(3);
        held[10] = 1'b0;
        cycles(2);
        held[10] = 1'b1;
        cycles(8);
        check(row_o == 4'b1111, "R10 gap keeps hold", row_o, 4'b1111);
        check(pulses == base + 1, "R10 gap gives no pulse", pulses, base + 1);
        held = '0;
        cycles(20);
        check(pulses == base + 1, "R10 single pulse overall", pulses, base + 1);
        check(onehot(row_o), "R10 scan after release", row_o, 4'b0001);

        // R1 reset in the middle of a hold
        base = pulses;
        held[13] = 1'b1;                  // row 3 col 1 -> 0
        wait_pulse(base);
        check(last_code == 4'h0, "R6 code zero key", last_code, 4'h0);
        cycles(2);
        rst_n = 1'b0;
        cycles(2);
        check(row_o == 4'b0001, "R1 reset during hold", row_o, 4'b0001);
        check(key_valid_o == 1'b0, "R1 no pulse in reset", key_valid_o, 0);
        held = '0;
        rst_n = 1'b1;
        cycles(10);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fail);
        $finish;
    end
endmodule